// File: doc/BRIEF.md
# Multi-Size Fully Associative Translation Buffer

This block turns virtual page numbers into physical addresses. It holds a parameterised number of entries, 64 by default, and all of them are searched at once. Each entry pairs a tag word with a translation word. Each translation word carries its own page size, one of 8 KB, 64 KB, 512 KB or 4 MB, so entries of different sizes can sit side by side.

A lookup presents the following:
- the virtual page number;
- the access kind: load, store, instruction fetch or non-faulting load;
- the requester's privilege;
- a context selector, plus a flag that says the processor is inside a trap.

One clock later the block reports exactly one outcome:
- a clean hit, with a 41-bit physical address and rights;
- a miss;
- a data access exception;
- an instruction access exception;
- a write protection trap.

On any miss or fault, the block captures the faulting page and context in a tag access register. On any fault, it also builds a fault status word. A clean hit marks the entry as used.

Software fills entries through a one-entry-per-cycle write port. It can inspect an entry through a registered read port. The read port is also how the used mark becomes visible. Refill policy and trap entry are left to the surrounding logic.

Top module: `va_xlate_tlb`

## Requirements
- R1: An entry matches when all three of these hold:
  - its valid bit is 1;
  - its global bit is 1, or its tag context (tag bits [12:0]) equals the lookup context;
  - tag bits [63:13] equal the lookup page number, ignoring the low 3·s page-number bits, where s is the size field in translation bits [62:61]. The values 0, 1, 2 and 3 give 8 KB, 64 KB, 512 KB and 4 MB pages.

  When several entries match, the lowest index is used.
- R2: The lookup context is chosen as follows:
  - data selector 0 uses the primary context;
  - data selector 1 uses the secondary context;
  - data selector 2 or 3 uses context 0;
  - a fetch ignores the selector and uses the primary context outside a trap and context 0 inside one.

  Access kind codes are 0 load, 1 store, 2 fetch and 3 non-faulting load.
- R3: On a clean hit, the physical address is built from the frame field in translation bits [40:13], which supplies the bits above the page offset. The lookup page number supplies the offset bits from bit 13 up. Bits [12:0] of the address are 0. Outcomes other than a clean hit report address 0.
- R4: A user access (lk_user=1) to an entry whose privileged bit [2] is set is a privilege fault. For data accesses this raises the data exception. For fetches it raises the instruction exception.
- R5: Two more conditions give a data exception, and several fault bits may be set together:
  - a non-faulting load to an entry whose side-effect bit [3] is set;
  - a load or store to an entry whose no-fault-only bit [60] is set.
- R6: A store with no data exception, to an entry whose writable bit [1] is clear, raises the protection trap instead of a hit.
- R7: A clean hit sets the entry's used bit, which the read port shows at translation bit [58]. The read port shows the valid bit at bit [63]. A clean hit also reports the entry's writable bit (data accesses only) and its invert-endian bit [59]. A lookup that faults leaves the used bit unchanged.
- R8: On a miss or any fault, tag_access is loaded with the lookup page number in bits [63:13] and the lookup context in bits [12:0]. It is left unchanged on a hit.
- R9: Any fault loads the status word:
  - bit 0: valid;
  - bit 1: overwrite, equal to the old valid bit unless stat_clr is high in that cycle;
  - bit 2: store;
  - bit 3: non-faulting load;
  - bit 4: privileged requester;
  - bits [6:5]: context type, 1 primary, 2 secondary, 3 nucleus;
  - bit 7: privilege fault;
  - bit 8: side-effect fault;
  - bit 9: no-fault-only fault.

  stat_clr zeroes the status word. A miss leaves it unchanged.
- R10: A lookup accepted on one clock edge reports its single outcome on the next. A lookup presented in the same cycle as an entry write is dropped, and no response follows it.
- R11: After reset, no response is pending, the status word and tag_access are 0, and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 6 | Entry index to write |
| wr_tag | input | 64 | Tag word: page number [63:13], context [12:0] |
| wr_tte | input | 64 | Translation word |
| rd_idx | input | 6 | Entry index to read |
| rd_tag | output | 64 | Registered tag word of rd_idx |
| rd_tte | output | 64 | Registered translation word, with live valid and used bits |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | 51 | Virtual page number (VA[63:13]) |
| lk_kind | input | 2 | Access kind |
| lk_user | input | 1 | Requester is unprivileged |
| lk_csel | input | 2 | Data context selector |
| lk_trap | input | 1 | Processor is inside a trap |
| pri_ctx | input | 13 | Primary context |
| sec_ctx | input | 13 | Secondary context |
| stat_clr | input | 1 | Clear the status word |
| rsp_valid | output | 1 | Lookup outcome present |
| rsp_hit | output | 1 | Clean hit |
| rsp_miss | output | 1 | No entry matched |
| rsp_dexc | output | 1 | Data access exception |
| rsp_iexc | output | 1 | Instruction access exception |
| rsp_prot | output | 1 | Write protection trap |
| rsp_pa | output | 41 | Physical address |
| rsp_wr | output | 1 | Store allowed |
| rsp_ie | output | 1 | Invert-endian page |
| fault_status | output | 10 | Fault status word |
| tag_access | output | 64 | Faulting page and context |

## Verification
Two conditions are hard to reach from the ports.

The first is two overlapping entries that both match the same lookup. The stimulus writes two entries with one page number and context but different frames. The lookup must then return the lower entry's frame and that entry's invert-endian bit.

The second is the overwrite bit. It needs two faults in a row with no clear between them, then a clear, then a third fault, checked against a running model of the status register.

A further case is a lookup issued in the same cycle as a write to the entry it targets. The lookup is dropped; a later lookup shows that the write landed.

The used mark is followed through the read port before and after a clean hit, and after a lookup that faulted.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_LOAD   = 2'd0,
    ACC_STORE  = 2'd1,
    ACC_FETCH  = 2'd2,
    ACC_NFLOAD = 2'd3
  } acc_kind_e;

  localparam int TTE_W = 64;
  localparam int TB_VALID  = 63;
  localparam int TB_SZ_LO  = 61;
  localparam int TB_NFO    = 60;
  localparam int TB_IE     = 59;
  localparam int TB_USED   = 58;
  localparam int TB_SIDE   = 3;
  localparam int TB_PRIV   = 2;
  localparam int TB_WRITE  = 1;
  localparam int TB_GLOBAL = 0;

  localparam int ST_W      = 10;
  localparam int ST_VALID  = 0;
  localparam int ST_OVW    = 1;
  localparam int ST_STORE  = 2;
  localparam int ST_NF     = 3;
  localparam int ST_PMODE  = 4;
  localparam int ST_CT_LO  = 5;
  localparam int ST_FPRIV  = 7;
  localparam int ST_FSIDE  = 8;
  localparam int ST_FNFO   = 9;

  localparam logic [1:0] CT_PRI = 2'd1;
  localparam logic [1:0] CT_SEC = 2'd2;
  localparam logic [1:0] CT_NUC = 2'd3;
endpackage

// File: rtl/tlb_cam_cell.sv
module tlb_cam_cell #(
  parameter int VPN_W   = 51,
  parameter int CTX_W   = 13,
  parameter int SZ_STEP = 3
) (
  input  logic             valid,
  input  logic             global_pg,
  input  logic [1:0]       size,
  input  logic [VPN_W-1:0] tag_vpn,
  input  logic [CTX_W-1:0] tag_ctx,
  input  logic [VPN_W-1:0] vpn,
  input  logic [CTX_W-1:0] ctx,
  output logic             hit
);
  logic [VPN_W-1:0] keep;
  logic [VPN_W-1:0] diff;

  always_comb begin
    keep = {VPN_W{1'b1}} << (SZ_STEP * int'(size));
    diff = (tag_vpn ^ vpn) & keep;
    hit  = valid && (diff == '0) && (global_pg || (tag_ctx == ctx));
  end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
  parameter int N     = 64,
  parameter int IDX_W = 6
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    if (any) begin
      assert_lowest_R1: assert ((hits & ((N'(1) << idx) - N'(1))) == '0 && hits[idx]);
    end
  end
endmodule

// File: rtl/tlb_check.sv
module tlb_check
  import tlb_pkg::*;
#(
  parameter int PPN_W   = 28,
  parameter int PG_SHIFT = 13,
  parameter int SZ_STEP = 3
) (
  input  logic [1:0]              size,
  input  logic                    nfo,
  input  logic                    ie,
  input  logic                    side,
  input  logic                    priv,
  input  logic                    wr_ok,
  input  logic [PPN_W-1:0]        frame,
  input  logic [PPN_W-1:0]        va_ppn,
  input  logic [1:0]              kind,
  input  logic                    user,
  input  logic [1:0]              ctype,
  input  logic                    old_valid,
  output logic                    dexc,
  output logic                    iexc,
  output logic                    prot,
  output logic                    clean,
  output logic [PPN_W+PG_SHIFT-1:0] pa,
  output logic                    wr,
  output logic                    ie_o,
  output logic [ST_W-1:0]         stat
);
  logic [PPN_W-1:0] pkeep;
  logic is_f, pf, sef, nfof;

  always_comb begin
    is_f  = (kind == ACC_FETCH);
    pf    = priv & user;
    sef   = (kind == ACC_NFLOAD) & side;
    nfof  = !is_f && (kind != ACC_NFLOAD) && nfo;
    iexc  = is_f & pf;
    dexc  = !is_f & (pf | sef | nfof);
    prot  = !is_f & !dexc & (kind == ACC_STORE) & !wr_ok;
    clean = !(iexc | dexc | prot);
    pkeep = {PPN_W{1'b1}} << (SZ_STEP * int'(size));
    pa    = clean ? {(frame & pkeep) | (va_ppn & ~pkeep), {PG_SHIFT{1'b0}}} : '0;
    wr    = clean & !is_f & wr_ok;
    ie_o  = clean & ie;
    stat  = '0;
    stat[ST_VALID] = 1'b1;
    stat[ST_OVW]   = old_valid;
    stat[ST_STORE] = (kind == ACC_STORE);
    stat[ST_NF]    = (kind == ACC_NFLOAD);
    stat[ST_PMODE] = !user;
    stat[ST_CT_LO +: 2] = ctype;
    stat[ST_FPRIV] = pf;
    stat[ST_FSIDE] = sef;
    stat[ST_FNFO]  = nfof;
  end
endmodule

// File: rtl/va_xlate_tlb.sv
module va_xlate_tlb
  import tlb_pkg::*;
#(
  parameter int ENTRIES  = 64,
  parameter int VA_W     = 64,
  parameter int PA_W     = 41,
  parameter int CTX_W    = 13,
  parameter int PG_SHIFT = 13,
  parameter int SZ_STEP  = 3,
  localparam int IDX_W   = $clog2(ENTRIES),
  localparam int VPN_W   = VA_W - PG_SHIFT,
  localparam int PPN_W   = PA_W - PG_SHIFT
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VA_W-1:0]     wr_tag,
  input  logic [TTE_W-1:0]    wr_tte,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [VA_W-1:0]     rd_tag,
  output logic [TTE_W-1:0]    rd_tte,
  input  logic                lk_valid,
  input  logic [VPN_W-1:0]    lk_vpn,
  input  logic [1:0]          lk_kind,
  input  logic                lk_user,
  input  logic [1:0]          lk_csel,
  input  logic                lk_trap,
  input  logic [CTX_W-1:0]    pri_ctx,
  input  logic [CTX_W-1:0]    sec_ctx,
  input  logic                stat_clr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_dexc,
  output logic                rsp_iexc,
  output logic                rsp_prot,
  output logic [PA_W-1:0]     rsp_pa,
  output logic                rsp_wr,
  output logic                rsp_ie,
  output logic [ST_W-1:0]     fault_status,
  output logic [VA_W-1:0]     tag_access
);
  logic [VA_W-1:0]  tag_q [ENTRIES];
  logic [TTE_W-1:0] tte_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, used_q, hits;
  logic [TTE_W-1:0] rd_word;
  logic [CTX_W-1:0] ctx;
  logic [1:0] ctype;
  logic lk_go, any, dexc, iexc, prot, clean, wr, ie;
  logic [IDX_W-1:0] sel;
  logic [PA_W-1:0] pa;
  logic [ST_W-1:0] new_stat;

  // entry storage: plain array, no reset, so it may map onto memory
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      tte_q[wr_idx] <= wr_tte;
    end
    rd_tag <= tag_q[rd_idx];
    rd_tte <= rd_word;
  end

  always_comb begin
    rd_word = tte_q[rd_idx];
    rd_word[TB_VALID] = valid_q[rd_idx];
    rd_word[TB_USED]  = used_q[rd_idx];
  end

  always_comb begin
    lk_go = lk_valid & !wr_en;
    if (lk_kind == ACC_FETCH) begin
      ctx   = lk_trap ? '0 : pri_ctx;
      ctype = lk_trap ? CT_NUC : CT_PRI;
    end else begin
      case (lk_csel)
        2'd0:    begin ctx = pri_ctx; ctype = CT_PRI; end
        2'd1:    begin ctx = sec_ctx; ctype = CT_SEC; end
        default: begin ctx = '0;      ctype = CT_NUC; end
      endcase
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    tlb_cam_cell #(.VPN_W(VPN_W), .CTX_W(CTX_W), .SZ_STEP(SZ_STEP)) u_cell (
      .valid    (valid_q[g]),
      .global_pg(tte_q[g][TB_GLOBAL]),
      .size     (tte_q[g][TB_SZ_LO +: 2]),
      .tag_vpn  (tag_q[g][VA_W-1:PG_SHIFT]),
      .tag_ctx  (tag_q[g][CTX_W-1:0]),
      .vpn      (lk_vpn),
      .ctx      (ctx),
      .hit      (hits[g])
    );
  end

  tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hits(hits), .any(any), .idx(sel)
  );

  tlb_check #(.PPN_W(PPN_W), .PG_SHIFT(PG_SHIFT), .SZ_STEP(SZ_STEP)) u_chk (
    .size     (tte_q[sel][TB_SZ_LO +: 2]),
    .nfo      (tte_q[sel][TB_NFO]),
    .ie       (tte_q[sel][TB_IE]),
    .side     (tte_q[sel][TB_SIDE]),
    .priv     (tte_q[sel][TB_PRIV]),
    .wr_ok    (tte_q[sel][TB_WRITE]),
    .frame    (tte_q[sel][PA_W-1:PG_SHIFT]),
    .va_ppn   (lk_vpn[PPN_W-1:0]),
    .kind     (lk_kind),
    .user     (lk_user),
    .ctype    (ctype),
    .old_valid(fault_status[ST_VALID] & !stat_clr),
    .dexc     (dexc),
    .iexc     (iexc),
    .prot     (prot),
    .clean    (clean),
    .pa       (pa),
    .wr       (wr),
    .ie_o     (ie),
    .stat     (new_stat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q      <= '0;
      used_q       <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_miss     <= 1'b0;
      rsp_dexc     <= 1'b0;
      rsp_iexc     <= 1'b0;
      rsp_prot     <= 1'b0;
      rsp_pa       <= '0;
      rsp_wr       <= 1'b0;
      rsp_ie       <= 1'b0;
      fault_status <= '0;
      tag_access   <= '0;
    end else begin
      rsp_valid <= lk_go;
      rsp_hit   <= lk_go & any & clean;
      rsp_miss  <= lk_go & !any;
      rsp_dexc  <= lk_go & any & dexc;
      rsp_iexc  <= lk_go & any & iexc;
      rsp_prot  <= lk_go & any & prot;
      rsp_pa    <= (lk_go & any) ? pa : '0;
      rsp_wr    <= lk_go & any & wr;
      rsp_ie    <= lk_go & any & ie;
      if (wr_en) begin
        valid_q[wr_idx] <= wr_tte[TB_VALID];
        used_q[wr_idx]  <= wr_tte[TB_USED];
      end
      if (lk_go & any & clean) used_q[sel] <= 1'b1;
      if (lk_go & !(any & clean))
        tag_access <= {lk_vpn, PG_SHIFT'(ctx)};
      if (lk_go & any & !clean) fault_status <= new_stat;
      else if (stat_clr)        fault_status <= '0;
    end
  end

  assert_one_outcome_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_dexc, rsp_iexc, rsp_prot}) == 1);
  assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit | rsp_miss | rsp_dexc | rsp_iexc | rsp_prot));
  assert_write_wins_R10: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en) |-> !rsp_valid);
  assert_tagacc_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss | rsp_dexc | rsp_iexc | rsp_prot) |->
      tag_access[VA_W-1:PG_SHIFT] == $past(lk_vpn));
  assert_overwrite_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_dexc | rsp_iexc | rsp_prot) |->
      fault_status[ST_VALID] &&
      fault_status[ST_OVW] == ($past(fault_status[ST_VALID]) && !$past(stat_clr)));
  assert_miss_keeps_R9: assert property (@(posedge clk) disable iff (rst)
    (rsp_miss && !$past(stat_clr)) |-> $stable(fault_status));
  assert_used_set_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> used_q[$past(sel)]);
endmodule

// File: tb/sim_va_xlate_tlb.sv
module sim_va_xlate_tlb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic wr_en = 0; logic [5:0] wr_idx = 0; logic [63:0] wr_tag = 0, wr_tte = 0;
  logic [5:0] rd_idx = 0; logic [63:0] rd_tag, rd_tte;
  logic lk_valid = 0; logic [50:0] lk_vpn = 0; logic [1:0] lk_kind = 0;
  logic lk_user = 0; logic [1:0] lk_csel = 0; logic lk_trap = 0;
  logic [12:0] pri_ctx = 13'd5, sec_ctx = 13'd7; logic stat_clr = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_dexc, rsp_iexc, rsp_prot, rsp_wr, rsp_ie;
  logic [40:0] rsp_pa; logic [9:0] fault_status; logic [63:0] tag_access;

  va_xlate_tlb u0 (.*);

  typedef struct packed {
    logic hit, miss, dexc, iexc, prot;
    logic [40:0] pa; logic wr, ie; logic [9:0] st; logic [63:0] ta;
  } exp_t;

  exp_t q[$]; string nq[$];
  int checks = 0, errors = 0;
  logic [63:0] m_tag [64]; logic [63:0] m_tte [64];
  logic [9:0] m_st = 0; logic [63:0] m_ta = 0;

  function automatic logic [63:0] mk(input logic [1:0] s, input logic nfo, ie,
      input logic [40:0] pa, input logic side, priv, wok, glob);
    logic [63:0] t = '0;
    t[63] = 1'b1; t[62:61] = s; t[60] = nfo; t[59] = ie;
    t[40:13] = pa[40:13]; t[3] = side; t[2] = priv; t[1] = wok; t[0] = glob;
    return t;
  endfunction

  task automatic put(input int i, input logic [63:0] va, input logic [12:0] c, input logic [63:0] t);
    @(negedge clk);
    wr_en = 1; wr_idx = 6'(i); wr_tag = {va[63:13], c}; wr_tte = t;
    m_tag[i] = {va[63:13], c}; m_tte[i] = t;
    @(negedge clk);
    wr_en = 0;
  endtask

  function automatic exp_t model(input logic [63:0] va, input logic [1:0] k,
      input logic u, input logic [1:0] cs, input logic tr);
    exp_t e = '0; logic [12:0] c; logic [1:0] ct; int f = -1; int pb;
    logic [63:0] t, lm, base; logic pf, sef, nfof, fault;
    if (k == 2) begin c = tr ? 13'd0 : pri_ctx; ct = tr ? 2'd3 : 2'd1; end
    else if (cs == 0) begin c = pri_ctx; ct = 2'd1; end
    else if (cs == 1) begin c = sec_ctx; ct = 2'd2; end
    else begin c = 13'd0; ct = 2'd3; end
    for (int i = 0; i < 64; i++) begin
      if (f < 0 && m_tte[i][63]) begin
        pb = 13 + 3 * int'(m_tte[i][62:61]);
        if ((va >> pb) == (m_tag[i] >> pb) && (m_tte[i][0] || m_tag[i][12:0] == c)) f = i;
      end
    end
    if (f < 0) begin
      e.miss = 1; m_ta = {va[63:13], c};
    end else begin
      t = m_tte[f]; pb = 13 + 3 * int'(t[62:61]);
      pf = t[2] & u; sef = (k == 3) & t[3]; nfof = (k == 0 || k == 1) & t[60];
      if (k == 2) begin e.iexc = pf; sef = 0; nfof = 0; end
      else begin
        e.dexc = pf | sef | nfof;
        e.prot = !e.dexc && k == 1 && !t[1];
      end
      fault = e.iexc | e.dexc | e.prot;
      if (fault) begin
        m_ta = {va[63:13], c};
        m_st = {nfof, sef, pf, ct, !u, k == 3, k == 1, m_st[0], 1'b1};
      end else begin
        e.hit = 1;
        lm = (64'd1 << pb) - 1;
        base = {23'd0, t[40:13], 13'd0};
        base = (base & ~lm) | (va & lm & ~64'h1fff);
        e.pa = base[40:0]; e.wr = (k != 2) & t[1]; e.ie = t[59];
      end
    end
    e.st = m_st; e.ta = m_ta;
    return e;
  endfunction

  task automatic look(input string nm, input logic [63:0] va, input logic [1:0] k,
      input logic u, input logic [1:0] cs, input logic tr);
    @(negedge clk);
    q.push_back(model(va, k, u, cs, tr)); nq.push_back(nm);
    lk_valid = 1; lk_vpn = va[63:13]; lk_kind = k; lk_user = u; lk_csel = cs; lk_trap = tr;
    @(negedge clk);
    lk_valid = 0;
  endtask

  task automatic chk(input string nm, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", nm, act, exp);
    end
  endtask

  task automatic rd_used(input string nm, input int i, input logic exp);
    @(negedge clk); rd_idx = 6'(i);
    @(negedge clk); chk(nm, {63'd0, rd_tte[58]}, {63'd0, exp});
  endtask

  // monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      exp_t a, e; string nm;
      a = '{rsp_hit, rsp_miss, rsp_dexc, rsp_iexc, rsp_prot, rsp_pa, rsp_wr, rsp_ie,
            fault_status, tag_access};
      checks++;
      if (q.size() == 0) begin
        errors++; $display("FAIL R10 unexpected response actual %h expected none", a);
      end else begin
        e = q.pop_front(); nm = nq.pop_front();
        if (a !== e) begin
          errors++; $display("FAIL %s actual %h expected %h", nm, a, e);
        end
      end
    end
  end

  bit done = 0;
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors); $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin m_tte[i] = '0; m_tag[i] = '0; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R11 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    chk("R11 status", {54'd0, fault_status}, 64'd0);
    chk("R11 tag_access", tag_access, 64'd0);
    look("R11 empty miss", 64'h0000_0040_0000_2000, 0, 1, 0, 0);

    put(0, 64'h0000_0040_0000_2000, 13'd5, mk(0, 0, 0, 41'h1_2345_6000, 0, 0, 1, 0));
    put(1, 64'h0000_0080_0001_0000, 13'd9, mk(1, 0, 0, 41'h0_0ABC_0000, 0, 0, 1, 1));
    put(2, 64'h0000_00C0_0040_0000, 13'd0, mk(3, 0, 0, 41'h1_FF80_0000, 0, 1, 1, 0));
    put(3, 64'h0000_0100_0008_0000, 13'd5, mk(2, 0, 0, 41'h0_3008_0000, 0, 0, 0, 0));
    put(4, 64'h0000_0200_0000_0000, 13'd5, mk(0, 0, 0, 41'h0_0444_0000, 1, 0, 1, 0));
    put(5, 64'h0000_0200_0000_2000, 13'd5, mk(0, 1, 0, 41'h0_0555_2000, 0, 0, 1, 0));
    put(6, 64'h0000_0300_0000_0000, 13'd5, mk(0, 0, 0, 41'h0_0111_0000, 0, 0, 1, 0));
    put(7, 64'h0000_0300_0000_0000, 13'd5, mk(0, 0, 1, 41'h0_0222_0000, 0, 0, 1, 0));
    put(8, 64'h0000_0300_0000_4000, 13'd5, mk(0, 0, 1, 41'h0_0333_4000, 0, 0, 1, 0));
    put(9, 64'h0000_0400_0000_0000, 13'd7, mk(0, 0, 0, 41'h0_0999_0000, 0, 0, 1, 0));

    rd_used("R7 used clear before hit", 0, 0);
    look("R1 R3 8K hit", 64'h0000_0040_0000_2000, 0, 1, 0, 0);
    rd_used("R7 used set after hit", 0, 1);
    pri_ctx = 13'd6;
    look("R1 R8 context mismatch miss", 64'h0000_0040_0000_2000, 0, 1, 0, 0);
    look("R1 R3 64K global hit", 64'h0000_0080_0001_E000, 0, 1, 0, 0);
    pri_ctx = 13'd5;
    look("R4 R9 user to privileged page", 64'h0000_00C0_0052_3000, 0, 1, 2, 0);
    rd_used("R7 used unchanged after fault", 2, 0);
    look("R3 4M kernel hit", 64'h0000_00C0_0052_3000, 0, 0, 2, 0);
    look("R6 R9 store to read-only 512K", 64'h0000_0100_000F_4000, 1, 1, 0, 0);
    look("R3 R7 512K load hit", 64'h0000_0100_000F_4000, 0, 1, 0, 0);
    look("R5 R9 non-faulting load side-effect", 64'h0000_0200_0000_0000, 3, 1, 0, 0);
    look("R5 normal load side-effect page", 64'h0000_0200_0000_0000, 0, 1, 0, 0);
    look("R5 load to no-fault-only page", 64'h0000_0200_0000_2000, 0, 0, 0, 0);
    look("R5 non-faulting load no-fault-only", 64'h0000_0200_0000_2000, 3, 0, 0, 0);
    look("R1 R7 lowest index wins", 64'h0000_0300_0000_0000, 1, 1, 0, 0);
    look("R7 invert-endian flag", 64'h0000_0300_0000_4000, 0, 1, 0, 0);
    look("R2 secondary context hit", 64'h0000_0400_0000_0000, 0, 1, 1, 0);
    look("R2 R8 primary misses secondary entry", 64'h0000_0400_0000_0000, 0, 1, 0, 0);
    look("R2 fetch in trap uses context 0", 64'h0000_00C0_0040_0000, 2, 0, 1, 1);
    look("R4 R9 user fetch privileged page", 64'h0000_00C0_0040_0000, 2, 1, 0, 1);
    look("R2 fetch outside trap primary", 64'h0000_0040_0000_2000, 2, 1, 3, 0);
    @(negedge clk); stat_clr = 1; m_st = '0;
    @(negedge clk); stat_clr = 0;
    look("R9 status after clear stays on miss", 64'h0000_0700_0000_0000, 0, 1, 0, 0);
    look("R9 first fault after clear no overwrite", 64'h0000_0100_000F_4000, 1, 0, 0, 0);
    look("R9 second fault sets overwrite", 64'h0000_0200_0000_0000, 3, 0, 0, 0);

    // R10: write and lookup in the same cycle, lookup dropped
    @(negedge clk);
    wr_en = 1; wr_idx = 6'd10; wr_tag = {51'h0000_0500_0000_0 >> 1, 13'd5};
    wr_tag = {64'h0000_0500_0000_0000 >> 13, 13'd5}[63:0];
    wr_tte = mk(0, 0, 0, 41'h0_0AAA_0000, 0, 0, 1, 0);
    m_tag[10] = wr_tag; m_tte[10] = wr_tte;
    lk_valid = 1; lk_vpn = 51'(64'h0000_0500_0000_0000 >> 13); lk_kind = 0; lk_user = 1; lk_csel = 0;
    @(negedge clk);
    wr_en = 0; lk_valid = 0;
    chk("R10 lookup during write dropped", {63'd0, rsp_valid}, 64'd0);
    look("R10 write landed", 64'h0000_0500_0000_0000, 0, 1, 0, 0);

    repeat (3) @(negedge clk);
    chk("R10 all responses seen", 64'(q.size()), 64'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule